// File: doc/BRIEF.md
# Voice Codec Event Flag and Interrupt Controller

This block keeps the three completion flags of a voice codec and drives an active-high interrupt request line toward a host microcontroller. The codec core reports a finished record operation, a finished playback operation and the end of each 1024-bit encoder page with single-cycle pulses. Each flag then stays set until its own clearing condition occurs. The record and playback flags clear when the next command of the same kind is loaded. The page flag clears when the host reads status. A general reset command clears all three flags.

The host learns about events through the interrupt line. Each source can raise that line only while its enable bit is set. When the line is asserted, the host reads an 8-bit status word that holds the three flags and the current 5-bit power level. The status word is a live view of the flags, so a read returns the values from before the read clears anything. The read also drops the interrupt line, unless a new enabled event arrives at the same edge.

Top module: `codec_irq_status`

## Requirements
- R1: While rstN is low, all three flags and irq are 0, asynchronously. They stay 0 after release until an event arrives.
- R2: statusWord bit 7 is the record-done flag, bit 6 the playback-done flag, bit 5 the page-ready flag, and bits 4:0 equal powerLevel combinationally.
- R3: A storeDone pulse sets the record-done flag at the next edge. A storeLoad pulse clears it. If both pulses arrive in the same cycle, the flag is set.
- R4: A playDone pulse sets the playback-done flag at the next edge. A playLoad pulse clears it. If both pulses arrive in the same cycle, the flag is set.
- R5: A pageDone pulse sets the page-ready flag. A statusRead pulse clears it. If both pulses arrive in the same cycle, the flag is set.
- R6: A genReset pulse clears all flags and irq at the next edge. It takes priority over every other input in the same cycle.
- R7: When a flag AND its enable goes from 0 to 1, irq is 1 from the edge one cycle later. This also happens when the enable rises while the flag is already set. A flag whose enable is 0 never raises irq.
- R8: A statusRead pulse clears irq at the next edge, unless an R7 set falls on the same edge. In that case irq stays 1.
- R9: In the cycle where statusRead is high, statusWord still shows the flags as they were before the read.
- R10: statusRead does not change the record-done or playback-done flags. A command load of one kind does not change the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| storeDone | input | 1 | Record command finished (one-cycle pulse) |
| playDone | input | 1 | Playback command finished (one-cycle pulse) |
| pageDone | input | 1 | Encoder page of 1024 bits finished (one-cycle pulse) |
| storeLoad | input | 1 | Next record command loaded |
| playLoad | input | 1 | Next playback command loaded |
| genReset | input | 1 | General reset command strobe |
| enStore | input | 1 | Interrupt enable for record-done |
| enPlay | input | 1 | Interrupt enable for playback-done |
| enPower | input | 1 | Interrupt enable for page-ready |
| statusRead | input | 1 | Host reads the status word |
| powerLevel | input | 5 | Current power reading |
| statusWord | output | 8 | Flags in bits 7:5, power reading in bits 4:0 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a status read that falls in the same cycle as a new interrupt set. In that cycle the read must clear the page flag and leave the interrupt request asserted. The stimulus gets there by timing the read for the single cycle after an enabled done pulse. In that cycle the flag is visible but the interrupt has not yet risen. A second directed case raises an enable while its flag is already held high. A randomized phase then mixes all strobes at low rates, and a behavioural model is compared on every clock.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int SRC_N = 3;
  localparam int SRC_STORE = 2;
  localparam int SRC_PLAY = 1;
  localparam int SRC_POWER = 0;

  typedef struct packed {
    logic [SRC_N-1:0] setFlag;
    logic [SRC_N-1:0] clrFlag;
    logic             wipe;
  } flagCtl_t;
endpackage

// File: rtl/codec_irq_flags.sv
module codec_irq_flags
  import codec_irq_pkg::*;
#(
  parameter int PWR_W = 5,
  localparam int STAT_W = PWR_W + SRC_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCtl_t          ctl,
  input  logic [PWR_W-1:0]  powerLevel,
  output logic [SRC_N-1:0]  flags,
  output logic [STAT_W-1:0] statusWord
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    logic flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ <= 1'b0;
      end else if (ctl.wipe) begin
        flagQ <= 1'b0;
      end else if (ctl.setFlag[i]) begin
        flagQ <= 1'b1;
      end else if (ctl.clrFlag[i]) begin
        flagQ <= 1'b0;
      end
    end
    assign flags[i] = flagQ;
  end

  assign statusWord = {flags, powerLevel};
endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl
  import codec_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             storeDone,
  input  logic             playDone,
  input  logic             pageDone,
  input  logic             storeLoad,
  input  logic             playLoad,
  input  logic             genReset,
  input  logic             statusRead,
  input  logic [SRC_N-1:0] enables,
  input  logic [SRC_N-1:0] flags,
  output flagCtl_t         ctl,
  output logic             irq
);
  logic [SRC_N-1:0] termNow;
  logic [SRC_N-1:0] termQ;
  logic             irqQ;
  logic             irqSet;

  always_comb begin
    ctl = '0;
    ctl.setFlag[SRC_STORE] = storeDone;
    ctl.setFlag[SRC_PLAY]  = playDone;
    ctl.setFlag[SRC_POWER] = pageDone;
    ctl.clrFlag[SRC_STORE] = storeLoad;
    ctl.clrFlag[SRC_PLAY]  = playLoad;
    ctl.clrFlag[SRC_POWER] = statusRead;
    ctl.wipe               = genReset;
  end

  assign termNow = flags & enables;
  assign irqSet  = |(termNow & ~termQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termQ <= '0;
      irqQ  <= 1'b0;
    end else if (genReset) begin
      termQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      termQ <= termNow;
      if (irqSet) begin
        irqQ <= 1'b1;
      end else if (statusRead) begin
        irqQ <= 1'b0;
      end
    end
  end

  assign irq = irqQ;
endmodule

// File: rtl/codec_irq_status.sv
module codec_irq_status
  import codec_irq_pkg::*;
#(
  parameter int PWR_W = 5,
  localparam int STAT_W = PWR_W + SRC_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              storeDone,
  input  logic              playDone,
  input  logic              pageDone,
  input  logic              storeLoad,
  input  logic              playLoad,
  input  logic              genReset,
  input  logic              enStore,
  input  logic              enPlay,
  input  logic              enPower,
  input  logic              statusRead,
  input  logic [PWR_W-1:0]  powerLevel,
  output logic [STAT_W-1:0] statusWord,
  output logic              irq
);
  flagCtl_t         ctl;
  logic [SRC_N-1:0] flags;
  logic [SRC_N-1:0] enables;

  always_comb begin
    enables = '0;
    enables[SRC_STORE] = enStore;
    enables[SRC_PLAY]  = enPlay;
    enables[SRC_POWER] = enPower;
  end

  codec_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .storeDone(storeDone), .playDone(playDone), .pageDone(pageDone),
    .storeLoad(storeLoad), .playLoad(playLoad), .genReset(genReset),
    .statusRead(statusRead), .enables(enables), .flags(flags),
    .ctl(ctl), .irq(irq)
  );

  codec_irq_flags #(.PWR_W(PWR_W)) u_flags (
    .clk(clk), .rstN(rstN), .ctl(ctl), .powerLevel(powerLevel),
    .flags(flags), .statusWord(statusWord)
  );
endmodule

// File: rtl/codec_irq_status_chk.sv
module codec_irq_status_chk #(
  parameter int PWR_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               storeDone,
  input logic               playDone,
  input logic               pageDone,
  input logic               storeLoad,
  input logic               playLoad,
  input logic               genReset,
  input logic               enStore,
  input logic               enPlay,
  input logic               enPower,
  input logic               statusRead,
  input logic [PWR_W-1:0]   powerLevel,
  input logic [PWR_W+2:0]   statusWord,
  input logic               irq
);
  // R3
  store_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storeDone && !genReset) |=> statusWord[PWR_W+2]);
  // R3
  store_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[PWR_W+2]) |-> $past(storeLoad || genReset));
  // R4
  play_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playDone && !genReset) |=> statusWord[PWR_W+1]);
  // R5
  page_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && !genReset) |=> statusWord[PWR_W]);
  // R6
  wipe_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    genReset |=> (statusWord[PWR_W+2:PWR_W] == 3'b000 && !irq));
  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((statusWord[PWR_W+2] && enStore) ||
                         (statusWord[PWR_W+1] && enPlay) ||
                         (statusWord[PWR_W] && enPower)));
  // R8
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(statusRead || genReset));
  // R2
  power_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[PWR_W-1:0] == powerLevel);
endmodule

bind codec_irq_status codec_irq_status_chk #(.PWR_W(PWR_W)) u_chk (
  .clk(clk), .rstN(rstN), .storeDone(storeDone), .playDone(playDone),
  .pageDone(pageDone), .storeLoad(storeLoad), .playLoad(playLoad),
  .genReset(genReset), .enStore(enStore), .enPlay(enPlay), .enPower(enPower),
  .statusRead(statusRead), .powerLevel(powerLevel), .statusWord(statusWord),
  .irq(irq)
);

// File: tb/codec_irq_status_bench.sv
module codec_irq_status_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic storeDone = 0, playDone = 0, pageDone = 0;
  logic storeLoad = 0, playLoad = 0, genReset = 0, statusRead = 0;
  logic enStore = 0, enPlay = 0, enPower = 0;
  logic [4:0] powerLevel = 5'h13;
  logic [7:0] statusWord;
  logic irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";

  bit mStore, mPlay, mPower, mIrq;
  bit [2:0] mTermQ;

  always #5 clk = ~clk;

  codec_irq_status u_codec_irq_status (
    .clk(clk), .rstN(rstN), .storeDone(storeDone), .playDone(playDone),
    .pageDone(pageDone), .storeLoad(storeLoad), .playLoad(playLoad),
    .genReset(genReset), .enStore(enStore), .enPlay(enPlay), .enPower(enPower),
    .statusRead(statusRead), .powerLevel(powerLevel), .statusWord(statusWord),
    .irq(irq)
  );

  // Behavioural reference model
  always @(posedge clk or negedge rstN) begin
    bit [2:0] term;
    if (!rstN) begin
      mStore = 0; mPlay = 0; mPower = 0; mIrq = 0; mTermQ = 0;
    end else if (genReset) begin
      mStore = 0; mPlay = 0; mPower = 0; mIrq = 0; mTermQ = 0;
    end else begin
      term = {mStore & enStore, mPlay & enPlay, mPower & enPower};
      if ((term & ~mTermQ) != 0) mIrq = 1;
      else if (statusRead) mIrq = 0;
      mTermQ = term;
      if (storeDone) mStore = 1; else if (storeLoad) mStore = 0;
      if (playDone) mPlay = 1; else if (playLoad) mPlay = 0;
      if (pageDone) mPower = 1; else if (statusRead) mPower = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareModel();
    logic [7:0] expWord;
    expWord = {mStore, mPlay, mPower, powerLevel};
    chk(statusWord === expWord, curReq, statusWord, expWord);
    chk(irq === mIrq, curReq, irq, mIrq);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    storeDone = 0; playDone = 0; pageDone = 0;
    storeLoad = 0; playLoad = 0; genReset = 0; statusRead = 0;
    compareModel();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state and R2 power passthrough
    chk(statusWord === 8'h13, "R1", statusWord, 8'h13);
    chk(irq === 1'b0, "R1", irq, 0);
    rstN = 1;
    tick();
    chk(statusWord === 8'h13, "R1", statusWord, 8'h13);

    // R2 field positions
    curReq = "R2";
    powerLevel = 5'h0a;
    #1 chk(statusWord[4:0] === 5'h0a, "R2", statusWord[4:0], 5'h0a);
    tick();

    // R3 record flag and irq
    curReq = "R3";
    enStore = 1;
    storeDone = 1; tick();
    chk(statusWord[7] === 1'b1, "R3", statusWord[7], 1);
    chk(irq === 1'b0, "R7", irq, 0);
    tick();
    chk(irq === 1'b1, "R7", irq, 1);
    curReq = "R10";
    statusRead = 1;
    #1 chk(statusWord[7] === 1'b1, "R9", statusWord[7], 1);
    tick();
    chk(statusWord[7] === 1'b1, "R10", statusWord[7], 1);
    chk(irq === 1'b0, "R8", irq, 0);
    playLoad = 1; tick();
    chk(statusWord[7] === 1'b1, "R10", statusWord[7], 1);
    curReq = "R3";
    storeLoad = 1; tick();
    chk(statusWord[7] === 1'b0, "R3", statusWord[7], 0);
    storeDone = 1; storeLoad = 1; tick();
    chk(statusWord[7] === 1'b1, "R3", statusWord[7], 1);
    tick(); tick();
    statusRead = 1; tick();

    // R4 playback flag, disabled source, late enable
    curReq = "R4";
    playDone = 1; tick();
    chk(statusWord[6] === 1'b1, "R4", statusWord[6], 1);
    tick(); tick();
    chk(irq === 1'b0, "R7", irq, 0);
    curReq = "R7";
    enPlay = 1; tick(); tick();
    chk(irq === 1'b1, "R7", irq, 1);
    statusRead = 1; tick();
    curReq = "R4";
    playDone = 1; playLoad = 1; tick();
    chk(statusWord[6] === 1'b1, "R4", statusWord[6], 1);
    playLoad = 1; tick();
    chk(statusWord[6] === 1'b0, "R4", statusWord[6], 0);

    // R5 page flag, R9 pre-clear read, same-cycle set/clear
    curReq = "R5";
    enPower = 1;
    pageDone = 1; tick();
    statusRead = 1;
    #1 chk(statusWord[5] === 1'b1, "R9", statusWord[5], 1);
    tick();
    chk(statusWord[5] === 1'b0, "R5", statusWord[5], 0);
    chk(irq === 1'b1, "R8", irq, 1);
    statusRead = 1; tick();
    chk(irq === 1'b0, "R8", irq, 0);
    pageDone = 1; statusRead = 1; tick();
    chk(statusWord[5] === 1'b1, "R5", statusWord[5], 1);
    tick();
    statusRead = 1; tick();

    // R6 general reset beats simultaneous events
    curReq = "R6";
    storeDone = 1; playDone = 1; tick(); tick();
    genReset = 1; pageDone = 1; storeDone = 1; tick();
    chk(statusWord[7:5] === 3'b000, "R6", statusWord[7:5], 0);
    chk(irq === 1'b0, "R6", irq, 0);
    tick();

    // R1 asynchronous reset mid-run
    curReq = "R1";
    storeDone = 1; pageDone = 1; tick(); tick();
    rstN = 0;
    #2 chk(statusWord[7:5] === 3'b000 && irq === 1'b0, "R1", {statusWord[7:5], irq}, 0);
    @(negedge clk); rstN = 1;
    tick();

    // Randomized mix
    curReq = "R2";
    for (int i = 0; i < 600; i++) begin
      storeDone = ($urandom_range(0, 9) == 0);
      playDone = ($urandom_range(0, 9) == 0);
      pageDone = ($urandom_range(0, 7) == 0);
      storeLoad = ($urandom_range(0, 9) == 0);
      playLoad = ($urandom_range(0, 9) == 0);
      statusRead = ($urandom_range(0, 5) == 0);
      genReset = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 15) == 0) {enStore, enPlay, enPower} = 3'($urandom_range(0, 7));
      powerLevel = 5'($urandom_range(0, 31));
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule